// File: doc/BRIEF.md
# Dual-Issue Pairing Decider

This block sits at the issue stage of an in-order core that has two issue slots. Every cycle it looks at the class codes of the two oldest decoded instructions, the older one and the younger one. It decides whether both issue, only the older one issues, or nothing issues. It also reports which issue slot each issued instruction takes. Slot A is the first slot and slot B is the second.

Pairing is not symmetric. Each instruction class has its own permission to lead a pair (the older position) and its own permission to follow (the younger position). A few further rules apply on top of those permissions.

Loads and stores of three or four registers take more than one cycle. Their second cycle is held in a small registered reservation, and that reservation blocks issue for one cycle. A structural stall input and two per-instruction dependence flags block an instruction and everything younger than it.

When the younger instruction does not issue, the surrounding decode logic moves it into the older position for the next cycle.

Top module: `dual_issue_pair`

## Requirements
- R1: The class field is 4 bits, encoded as follows:
  - 0 branch, 1 call, 2 ALU with immediate, 3 ALU with register operands, 4 ALU with shifted operand
  - 5 multiply, 6 divide
  - 7 one- or two-register load, 8 three-register load, 9 four-register load
  - 10 one- or two-register store, 11 three-register store, 12 four-register store
  - 13 floating point, 14 SIMD, 15 reserved
- R2: An older instruction that is valid and not blocked issues. The issue count is at least 1 and its slot mask is 01 (bit 0 is slot A, bit 1 is slot B), or 11 for a wide access.
- R3: A branch (class 0) may lead or follow a pair. Two branch-class instructions (classes 0 and 1) never issue in the same cycle.
- R4: A call (class 1) never leads a pair. It issues alone or as the younger instruction.
- R5: An immediate ALU operation (class 2) may lead or follow a pair. A register or shifted ALU operation (class 3 or 4) may lead a pair only when the younger instruction is class 2, and it never follows.
- R6: The following classes issue alone in either position:
  - multiply, divide, SIMD and reserved (classes 5, 6, 14, 15)
  - three- and four-register accesses (classes 8, 9, 11, 12)

  Classes 7, 10 and 13 may lead a pair but never follow.
- R7: A three- or four-register access (classes 8, 9, 11, 12) that issues occupies both slots (mask 11) in its first cycle, and the issue count is 1.
- R8: In the cycle after such an access issues, the hold output shows the carried-over occupancy: 01 for three-register accesses and 11 for four-register accesses. In that cycle the issue count is 0. After reset the hold output is 00.
- R9: When the stall input or the older instruction's dependence flag is set, the issue count is 0 and no hold follows. When only the younger instruction's dependence flag is set, at most the older instruction issues.
- R10: The younger slot mask is 10 exactly when the issue count is 2, and 00 otherwise. Slot B is never used unless slot A is used in the same cycle. With no valid older instruction, nothing issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Structural hazard stall, blocks all issue |
| old_vld_i | input | 1 | Older instruction present |
| old_cls_i | input | 4 | Older instruction class (R1 encoding) |
| old_dep_i | input | 1 | Older instruction has an unresolved operand dependence |
| yng_vld_i | input | 1 | Younger instruction present |
| yng_cls_i | input | 4 | Younger instruction class (R1 encoding) |
| yng_dep_i | input | 1 | Younger instruction has an unresolved operand dependence |
| issue_cnt_o | output | 2 | Number of instructions issued this cycle (0, 1 or 2) |
| old_slots_o | output | 2 | Slots taken by the older instruction (bit 0 A, bit 1 B) |
| yng_slots_o | output | 2 | Slots taken by the younger instruction |
| hold_slots_o | output | 2 | Slots held by the second cycle of a wide access |

## Verification
Two functions of this block can fall in the same cycle: the carried-over reservation of a wide access, and a fresh pair of instructions that would issue on its own. To provoke this, every one of the 256 older/younger class combinations is followed directly by a cycle that presents a legal immediate-ALU pair. In that following cycle, the expected hold mask and issue count are derived from the class that issued one cycle earlier. The pairing result of each combination is judged against a rule model built in the bench from the per-class lead and follow permissions.

// File: rtl/dip_pkg.sv
package dip_pkg;
    localparam int CLS_W  = 4;
    localparam int SLOT_N = 2;

    typedef enum logic [CLS_W-1:0] {
        CL_BRANCH = 4'd0,  CL_CALL  = 4'd1,  CL_ALU_IMM = 4'd2,  CL_ALU_REG = 4'd3,
        CL_ALU_SHF = 4'd4, CL_MUL   = 4'd5,  CL_DIV     = 4'd6,  CL_LD_S    = 4'd7,
        CL_LD_3   = 4'd8,  CL_LD_4  = 4'd9,  CL_ST_S    = 4'd10, CL_ST_3    = 4'd11,
        CL_ST_4   = 4'd12, CL_FP    = 4'd13, CL_SIMD    = 4'd14, CL_RSVD    = 4'd15
    } cls_e;

    typedef struct packed {
        logic br_class;     // branch or call
        logic may_lead;     // can be the older of a pair
        logic may_follow;   // can be the younger of a pair
        logic needs_imm;    // leads only with an immediate ALU follower
        logic is_imm;       // immediate ALU op
        logic wide;         // multi-cycle access
        logic tail_full;    // second cycle takes both slots
    } cls_props_t;

    typedef struct packed {
        logic [SLOT_N-1:0] tail;
    } dip_state_t;
endpackage

// File: rtl/dip_class_props.sv
module dip_class_props
    import dip_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_props_t       props_o
);
    always_comb begin
        props_o = '0;
        unique case (cls_e'(cls_i))
            CL_BRANCH:  begin props_o.br_class = 1'b1; props_o.may_lead = 1'b1; props_o.may_follow = 1'b1; end
            CL_CALL:    begin props_o.br_class = 1'b1; props_o.may_follow = 1'b1; end
            CL_ALU_IMM: begin props_o.is_imm = 1'b1; props_o.may_lead = 1'b1; props_o.may_follow = 1'b1; end
            CL_ALU_REG,
            CL_ALU_SHF: begin props_o.may_lead = 1'b1; props_o.needs_imm = 1'b1; end
            CL_LD_S,
            CL_ST_S,
            CL_FP:      props_o.may_lead = 1'b1;
            CL_LD_3,
            CL_ST_3:    props_o.wide = 1'b1;
            CL_LD_4,
            CL_ST_4:    begin props_o.wide = 1'b1; props_o.tail_full = 1'b1; end
            default:    props_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              old_vld_i,
    input  logic [CLS_W-1:0]  old_cls_i,
    input  logic              old_dep_i,
    input  logic              yng_vld_i,
    input  logic [CLS_W-1:0]  yng_cls_i,
    input  logic              yng_dep_i,
    output logic [1:0]        issue_cnt_o,
    output logic [SLOT_N-1:0] old_slots_o,
    output logic [SLOT_N-1:0] yng_slots_o,
    output logic [SLOT_N-1:0] hold_slots_o
);
    localparam logic [SLOT_N-1:0] SL_A    = SLOT_N'(1);
    localparam logic [SLOT_N-1:0] SL_B    = SLOT_N'(2);
    localparam logic [SLOT_N-1:0] SL_BOTH = SL_A | SL_B;

    logic [CLS_W-1:0] cls_in [SLOT_N];
    cls_props_t       props  [SLOT_N];
    assign cls_in[0] = old_cls_i;
    assign cls_in[1] = yng_cls_i;

    for (genvar g = 0; g < SLOT_N; g++) begin : g_props
        dip_class_props u_props (
            .cls_i   (cls_in[g]),
            .props_o (props[g])
        );
    end

    dip_state_t st_q, st_d;
    logic go_old, go_pair;

    always_comb begin
        st_d         = '0;
        hold_slots_o = st_q.tail;
        go_old  = old_vld_i && !stall_i && !old_dep_i && (st_q.tail == '0);
        go_pair = go_old && yng_vld_i && !yng_dep_i
                  && props[0].may_lead && props[1].may_follow
                  && !(props[0].br_class && props[1].br_class)
                  && (!props[0].needs_imm || props[1].is_imm);
        issue_cnt_o = go_pair ? 2'd2 : (go_old ? 2'd1 : 2'd0);
        old_slots_o = go_old ? (props[0].wide ? SL_BOTH : SL_A) : '0;
        yng_slots_o = go_pair ? SL_B : '0;
        if (go_old && props[0].wide)
            st_d.tail = props[0].tail_full ? SL_BOTH : SL_A;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_slotb_needs_slota_r10: assert property (@(posedge clk) disable iff (!rst_n)
        yng_slots_o[1] |-> (old_slots_o[0] && issue_cnt_o == 2'd2));
    p_no_branch_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_o == 2'd2) |-> !(old_cls_i <= 4'd1 && yng_cls_i <= 4'd1));
    p_call_not_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_o == 2'd2) |-> (old_cls_i != CL_CALL));
    p_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_o == 2'd2) |-> !(old_cls_i inside {CL_MUL, CL_DIV, CL_SIMD, CL_RSVD}
                                  || yng_cls_i inside {CL_MUL, CL_DIV, CL_SIMD, CL_RSVD}));
    p_wide_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_o != 2'd0 && old_cls_i inside {CL_LD_3, CL_LD_4, CL_ST_3, CL_ST_4})
        |-> (old_slots_o == SL_BOTH && issue_cnt_o == 2'd1));
    p_tail_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_o != 2'd0 && old_cls_i inside {CL_LD_4, CL_ST_4})
        |=> (hold_slots_o == SL_BOTH && issue_cnt_o == 2'd0));
    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i || old_dep_i) |-> (issue_cnt_o == 2'd0));
endmodule

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;
    logic clk = 1'b0;
    logic rst_n, stall, ov, od, yv, yd;
    logic [3:0] oc, yc;
    logic [1:0] cnt, osl, ysl, hsl;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_issue_pair u_dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall),
        .old_vld_i(ov), .old_cls_i(oc), .old_dep_i(od),
        .yng_vld_i(yv), .yng_cls_i(yc), .yng_dep_i(yd),
        .issue_cnt_o(cnt), .old_slots_o(osl), .yng_slots_o(ysl), .hold_slots_o(hsl)
    );

    function automatic bit lead_ok(int c);   return c inside {0, 2, 3, 4, 7, 10, 13}; endfunction
    function automatic bit follow_ok(int c); return c inside {0, 1, 2}; endfunction
    function automatic bit is_wide(int c);   return c inside {8, 9, 11, 12}; endfunction

    function automatic bit pairs(int o, int y);
        if (!lead_ok(o) || !follow_ok(y)) return 1'b0;
        if (o <= 1 && y <= 1) return 1'b0;
        if ((o == 3 || o == 4) && y != 2) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(bit s, bit ov_, int oc_, bit od_, bit yv_, int yc_, bit yd_);
        @(negedge clk);
        stall = s; ov = ov_; oc = 4'(oc_); od = od_; yv = yv_; yc = 4'(yc_); yd = yd_;
        #5;
    endtask

    function automatic logic [7:0] outs();
        return {cnt, osl, ysl, hsl};
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stall = 0; ov = 0; od = 0; yv = 0; yd = 0; oc = 0; yc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #5;
        chk("R8 reset hold/count", outs(), 8'h00);

        // Exhaustive class sweep, each followed by an immediate-ALU pair cycle
        for (int o = 0; o < 16; o++) begin
            for (int y = 0; y < 16; y++) begin
                logic [1:0] ec, eo, ey, eh;
                string tg;
                ec = pairs(o, y) ? 2'd2 : 2'd1;
                eo = is_wide(o) ? 2'b11 : 2'b01;
                ey = pairs(o, y) ? 2'b10 : 2'b00;
                if (is_wide(o))                  tg = "R1 R7 wide first cycle";
                else if (o <= 1 && y <= 1)       tg = "R1 R3 R4 branch-class pair";
                else if (o == 3 || o == 4)       tg = "R1 R5 reg/shift ALU";
                else if (o inside {5, 6, 14, 15} || y inside {5, 6, 14, 15}) tg = "R1 R6 alone";
                else                             tg = "R1 R2 R10 pairing";
                drive(0, 1, o, 0, 1, y, 0);
                chk(tg, outs(), {ec, eo, ey, 2'b00});
                eh = (o == 9 || o == 12) ? 2'b11 : (is_wide(o) ? 2'b01 : 2'b00);
                drive(0, 1, 2, 0, 1, 2, 0);
                if (eh != 2'b00) chk("R8 hold cycle blocks issue", outs(), {2'd0, 2'b00, 2'b00, eh});
                else             chk("R10 follow-up imm pair", outs(), {2'd2, 2'b01, 2'b10, 2'b00});
            end
        end

        drive(1, 1, 2, 0, 1, 2, 0);
        chk("R9 stall blocks all", outs(), 8'h00);
        drive(0, 1, 2, 1, 1, 2, 0);
        chk("R9 older dependence blocks all", outs(), 8'h00);
        drive(0, 1, 2, 0, 1, 2, 1);
        chk("R9 younger dependence older only", outs(), {2'd1, 2'b01, 2'b00, 2'b00});
        drive(0, 0, 2, 0, 1, 2, 0);
        chk("R10 no older valid", outs(), 8'h00);
        drive(0, 1, 0, 0, 0, 0, 0);
        chk("R2 older alone", outs(), {2'd1, 2'b01, 2'b00, 2'b00});
        drive(1, 1, 9, 0, 0, 0, 0);
        chk("R9 stalled wide issues nothing", outs(), 8'h00);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk("R9 stalled wide leaves no hold", outs(), 8'h00);
        drive(0, 1, 11, 0, 1, 2, 0);
        chk("R7 three-reg store first cycle", outs(), {2'd1, 2'b11, 2'b00, 2'b00});
        drive(1, 1, 2, 0, 0, 0, 0);
        chk("R8 hold persists under stall", outs(), {2'd0, 2'b00, 2'b00, 2'b01});
        drive(0, 1, 1, 0, 1, 0, 0);
        chk("R4 call older issues alone", outs(), {2'd1, 2'b01, 2'b00, 2'b00});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule